// File: doc/BRIEF.md
# Nested Prioritised Interrupt Sequencer

This block is a vectored interrupt controller for a small processor core. It models exception entry and exit as timed phases and moves no data. Each of a parameterised number of request lines is caught in a pending bit. Each source also has an enable bit and a programmable urgency level, and all of these are set through a narrow configuration write port. An arbiter finds the most urgent enabled pending source. A sequencer then runs a fixed-length save phase and strobes `handler_start` together with the source number on `handler_vec`.

The core reports the end of a handler with `exc_return`. If the core returns while another qualifying source is waiting, the sequencer skips the restore phase and chains straight into the next handler through a short phase. Otherwise it runs a restore phase, and a qualifying arrival can cut that phase short. A source that becomes more urgent during the save phase takes over the vector without lengthening entry. A stack of active urgency levels lets nested handlers unwind in the right order. An optional mode raises a sleep request once the last handler has returned to thread level.

Top module: `nis_sequencer`

## Requirements
- R1: A configuration write (`cfg_we`=1) acts at the next clock edge on source `cfg_idx`. `cfg_op` 0 sets its enable, 1 clears its enable, 2 loads its level from `cfg_data`, and 3 sets its pending bit. `cfg_op` 4 loads the sleep-on-exit mode from `cfg_data[0]`. Other codes do nothing.
- R2: A source becomes pending at the edge where its request line is sampled high after being sampled low, or through a set-pending write. Its pending bit clears at the edge where its handler starts. A disabled source keeps its pending bit but is never selected, and it is selected once it is enabled again.
- R3: Among enabled pending sources, the one with the numerically lowest level wins. On equal levels, the lower source index wins.
- R4: From idle, a source is accepted at the edge after it becomes pending. `handler_start` is a one-cycle pulse that rises 12 edges after acceptance, so 13 edges after the pending edge, and `handler_vec` carries the source index at the same time. Reset leaves both outputs and `sleep_req` at 0.
- R5: During the save phase or the chaining phase, an enabled pending source with a strictly lower level than the selected one replaces the selection. The strobe still comes at its original edge.
- R6: A running handler is preempted only by a source whose level is strictly lower than the active level. Active levels are stacked, so a return resumes the level that was interrupted.
- R7: A return with a waiting source strictly more urgent than the level returned to raises `handler_start` 6 edges after the return edge, and no restore phase runs. If a return and a preempting source coincide, the chaining path is taken. A return at thread level is ignored.
- R8: A return with nothing qualifying runs a 10-cycle restore phase. A qualifying source detected during that phase ends it, and `handler_start` follows 6 edges after the detection edge.
- R9: With sleep-on-exit set, `sleep_req` rises at the edge that ends a restore phase back to thread level, which is 10 edges after the return edge. It stays high while no enabled source is pending, and it falls one edge after an enabled source becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | N_IRQ | Request lines, captured on rising level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Configuration operation code |
| cfg_idx | input | IDXW | Source addressed by the write |
| cfg_data | input | PRIO_BITS | Level or mode value |
| exc_return | input | 1 | End-of-handler strobe from the core |
| handler_start | output | 1 | One-cycle strobe: handler begins |
| handler_vec | output | IDXW | Source index of the starting handler |
| sleep_req | output | 1 | Request for the core to sleep |

## Verification
The critical collisions are a return strobe landing in the same cycle as a source that would otherwise preempt, and a new arrival landing in the middle of a timed phase. The bench raises a more urgent source exactly one edge before the return, and it checks that the handler starts 6 edges later rather than 13. It also injects arrivals three edges into a save phase and two edges into a restore phase, then measures the strobe edge and the vector against counts derived from R4, R5 and R8. Across a sweep of level assignments, the full handler order is compared with a sort on (level, index) computed in the bench.

// File: rtl/nis_pkg.sv
package nis_pkg;

  typedef enum logic [1:0] {
    SQ_RUN   = 2'd0,
    SQ_STACK = 2'd1,
    SQ_TAIL  = 2'd2,
    SQ_UNSTK = 2'd3
  } sq_state_t;

  localparam logic [2:0] OP_EN_SET = 3'd0;
  localparam logic [2:0] OP_EN_CLR = 3'd1;
  localparam logic [2:0] OP_LEVEL  = 3'd2;
  localparam logic [2:0] OP_PEND   = 3'd3;
  localparam logic [2:0] OP_SLEEP  = 3'd4;

endpackage

// File: rtl/nis_regs.sv
module nis_regs
  import nis_pkg::*;
#(
  parameter int N_IRQ     = 8,
  parameter int PRIO_BITS = 3,
  localparam int IDXW     = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_IRQ-1:0]             irq_req,
  input  logic                         cfg_we,
  input  logic [2:0]                   cfg_op,
  input  logic [IDXW-1:0]              cfg_idx,
  input  logic [PRIO_BITS-1:0]         cfg_data,
  input  logic                         clr_vld,
  input  logic [IDXW-1:0]              clr_idx,
  output logic [N_IRQ-1:0]             pend,
  output logic [N_IRQ-1:0]             en,
  output logic [N_IRQ*PRIO_BITS-1:0]   level_flat,
  output logic                         sleep_on_exit
);

  logic [N_IRQ-1:0] req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= irq_req;
  end

  always_ff @(posedge clk) begin
    if (rst)                               sleep_on_exit <= 1'b0;
    else if (cfg_we && cfg_op == OP_SLEEP) sleep_on_exit <= cfg_data[0];
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    logic hit;
    logic rise;
    logic drop;
    assign hit  = cfg_we && (cfg_idx == IDXW'(i));
    assign rise = irq_req[i] && !req_q[i];
    assign drop = clr_vld && (clr_idx == IDXW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        en[i]                             <= 1'b0;
        level_flat[i*PRIO_BITS +: PRIO_BITS] <= '0;
        pend[i]                           <= 1'b0;
      end else begin
        if (hit && cfg_op == OP_EN_SET) en[i] <= 1'b1;
        if (hit && cfg_op == OP_EN_CLR) en[i] <= 1'b0;
        if (hit && cfg_op == OP_LEVEL)
          level_flat[i*PRIO_BITS +: PRIO_BITS] <= cfg_data;
        pend[i] <= (pend[i] && !drop) || rise || (hit && cfg_op == OP_PEND);
      end
    end
  end

endmodule

// File: rtl/nis_arbiter.sv
module nis_arbiter #(
  parameter int N_IRQ     = 8,
  parameter int PRIO_BITS = 3,
  localparam int IDXW     = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [N_IRQ-1:0]           pend,
  input  logic [N_IRQ-1:0]           en,
  input  logic [N_IRQ*PRIO_BITS-1:0] level_flat,
  output logic                       best_vld,
  output logic [IDXW-1:0]            best_idx,
  output logic [PRIO_BITS-1:0]       best_lvl
);

  // Ascending scan with strict compare: the lower index keeps a tie.
  always_comb begin
    best_vld = 1'b0;
    best_idx = '0;
    best_lvl = '1;
    for (int i = 0; i < N_IRQ; i++) begin
      if (pend[i] && en[i] &&
          (!best_vld || level_flat[i*PRIO_BITS +: PRIO_BITS] < best_lvl)) begin
        best_vld = 1'b1;
        best_idx = IDXW'(i);
        best_lvl = level_flat[i*PRIO_BITS +: PRIO_BITS];
      end
    end
  end

endmodule

// File: rtl/nis_prio_stack.sv
module nis_prio_stack #(
  parameter int PRIO_BITS = 3,
  localparam int DEPTH    = 2 ** PRIO_BITS,
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DW       = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 push,
  input  logic [PRIO_BITS-1:0] push_lvl,
  input  logic                 pop,
  output logic [PRIO_BITS:0]   top_lvl,
  output logic [PRIO_BITS:0]   under_lvl,
  output logic [DW-1:0]        depth
);

  localparam logic [PRIO_BITS:0] IDLE_LVL = {1'b1, {PRIO_BITS{1'b0}}};

  logic [PRIO_BITS-1:0] mem [DEPTH];
  logic [DW-1:0]        dm1;
  logic [DW-1:0]        dm2;

  assign dm1 = depth - DW'(1);
  assign dm2 = depth - DW'(2);

  always_ff @(posedge clk) begin
    if (push) mem[depth[AW-1:0]] <= push_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst)              depth <= '0;
    else if (push && !pop) depth <= depth + DW'(1);
    else if (pop && !push) depth <= dm1;
  end

  assign top_lvl   = (depth == '0)      ? IDLE_LVL : {1'b0, mem[dm1[AW-1:0]]};
  assign under_lvl = (depth < DW'(2))   ? IDLE_LVL : {1'b0, mem[dm2[AW-1:0]]};

endmodule

// File: rtl/nis_sequencer.sv
module nis_sequencer
  import nis_pkg::*;
#(
  parameter int N_IRQ       = 8,
  parameter int PRIO_BITS   = 3,
  parameter int STACK_CYC   = 12,
  parameter int TAIL_CYC    = 6,
  parameter int UNSTACK_CYC = 10,
  localparam int IDXW       = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int DEPTH      = 2 ** PRIO_BITS,
  localparam int SDW        = $clog2(DEPTH + 1),
  localparam int CNTW       = $clog2(STACK_CYC + TAIL_CYC + UNSTACK_CYC + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_IRQ-1:0]     irq_req,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_op,
  input  logic [IDXW-1:0]      cfg_idx,
  input  logic [PRIO_BITS-1:0] cfg_data,
  input  logic                 exc_return,
  output logic                 handler_start,
  output logic [IDXW-1:0]      handler_vec,
  output logic                 sleep_req
);

  logic [N_IRQ-1:0]           pend;
  logic [N_IRQ-1:0]           en;
  logic [N_IRQ*PRIO_BITS-1:0] level_flat;
  logic                       sleep_on_exit;

  logic                       best_vld;
  logic [IDXW-1:0]            best_idx;
  logic [PRIO_BITS-1:0]       best_lvl;

  logic [PRIO_BITS:0]         top_lvl;
  logic [PRIO_BITS:0]         under_lvl;
  logic [SDW-1:0]             depth;

  sq_state_t                  state;
  logic [CNTW-1:0]            cnt;
  logic [IDXW-1:0]            sel_idx;
  logic [PRIO_BITS-1:0]       sel_lvl;
  logic [IDXW-1:0]            sel_idx_n;
  logic [PRIO_BITS-1:0]       sel_lvl_n;

  logic                       beats_top;
  logic                       beats_under;
  logic                       beats_sel;
  logic                       entering;
  logic                       finish_entry;
  logic                       do_pop;
  logic                       any_ready;

  nis_regs #(.N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .irq_req      (irq_req),
    .cfg_we       (cfg_we),
    .cfg_op       (cfg_op),
    .cfg_idx      (cfg_idx),
    .cfg_data     (cfg_data),
    .clr_vld      (finish_entry),
    .clr_idx      (sel_idx_n),
    .pend         (pend),
    .en           (en),
    .level_flat   (level_flat),
    .sleep_on_exit(sleep_on_exit)
  );

  nis_arbiter #(.N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS)) u_arb (
    .pend      (pend),
    .en        (en),
    .level_flat(level_flat),
    .best_vld  (best_vld),
    .best_idx  (best_idx),
    .best_lvl  (best_lvl)
  );

  nis_prio_stack #(.PRIO_BITS(PRIO_BITS)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (finish_entry),
    .push_lvl (sel_lvl_n),
    .pop      (do_pop),
    .top_lvl  (top_lvl),
    .under_lvl(under_lvl),
    .depth    (depth)
  );

  assign any_ready    = |(pend & en);
  assign beats_top    = best_vld && ({1'b0, best_lvl} < top_lvl);
  assign beats_under  = best_vld && ({1'b0, best_lvl} < under_lvl);
  assign beats_sel    = best_vld && (best_lvl < sel_lvl);
  assign entering     = (state == SQ_STACK) || (state == SQ_TAIL);
  assign finish_entry = entering && (cnt == '0);
  assign do_pop       = (state == SQ_RUN) && exc_return && (depth != '0);

  // Late arrival: the selection may change on every entry cycle,
  // including the last one, without touching the counter.
  assign sel_idx_n = (entering && beats_sel) ? best_idx : sel_idx;
  assign sel_lvl_n = (entering && beats_sel) ? best_lvl : sel_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= SQ_RUN;
      cnt           <= '0;
      sel_idx       <= '0;
      sel_lvl       <= '0;
      handler_start <= 1'b0;
      handler_vec   <= '0;
      sleep_req     <= 1'b0;
    end else begin
      handler_start <= 1'b0;
      sel_idx       <= sel_idx_n;
      sel_lvl       <= sel_lvl_n;
      unique case (state)
        SQ_RUN: begin
          if (do_pop) begin
            if (beats_under) begin
              state   <= SQ_TAIL;
              cnt     <= CNTW'(TAIL_CYC - 1);
              sel_idx <= best_idx;
              sel_lvl <= best_lvl;
            end else begin
              state <= SQ_UNSTK;
              cnt   <= CNTW'(UNSTACK_CYC - 1);
            end
          end else if (beats_top) begin
            state   <= SQ_STACK;
            cnt     <= CNTW'(STACK_CYC - 1);
            sel_idx <= best_idx;
            sel_lvl <= best_lvl;
          end
        end
        SQ_STACK, SQ_TAIL: begin
          if (cnt == '0) begin
            state         <= SQ_RUN;
            handler_start <= 1'b1;
            handler_vec   <= sel_idx_n;
          end else begin
            cnt <= cnt - CNTW'(1);
          end
        end
        SQ_UNSTK: begin
          if (beats_top) begin
            state   <= SQ_TAIL;
            cnt     <= CNTW'(TAIL_CYC - 1);
            sel_idx <= best_idx;
            sel_lvl <= best_lvl;
          end else if (cnt == '0) begin
            state <= SQ_RUN;
            if (depth == '0 && sleep_on_exit) sleep_req <= 1'b1;
          end else begin
            cnt <= cnt - CNTW'(1);
          end
        end
        default: state <= SQ_RUN;
      endcase
      if (any_ready) sleep_req <= 1'b0;
    end
  end

endmodule

// File: rtl/nis_checker.sv
module nis_checker
  import nis_pkg::*;
#(
  parameter int CNTW  = 5,
  parameter int SDW   = 4,
  parameter int DEPTH = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            handler_start,
  input logic            sleep_req,
  input sq_state_t       state,
  input logic [CNTW-1:0] cnt,
  input logic [SDW-1:0]  depth,
  input logic            work_pending,
  input logic            exc_return
);

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    handler_start |=> !handler_start);

  p_start_after_count_r4: assert property (@(posedge clk) disable iff (rst)
    handler_start |-> (($past(state) == SQ_STACK || $past(state) == SQ_TAIL)
                       && $past(cnt) == '0));

  p_start_pushes_r6: assert property (@(posedge clk) disable iff (rst)
    handler_start |-> (depth == $past(depth) + SDW'(1)));

  p_depth_bound_r6: assert property (@(posedge clk) disable iff (rst)
    depth <= SDW'(DEPTH));

  p_return_leaves_run_r7: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_RUN && exc_return && depth != '0)
      |=> (state == SQ_TAIL || state == SQ_UNSTK));

  p_sleep_at_thread_r9: assert property (@(posedge clk) disable iff (rst)
    sleep_req |-> (state == SQ_RUN && depth == '0));

  p_sleep_wakes_r9: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && work_pending) |=> !sleep_req);

endmodule

bind nis_sequencer nis_checker #(.CNTW(CNTW), .SDW(SDW), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .handler_start(handler_start),
  .sleep_req    (sleep_req),
  .state        (state),
  .cnt          (cnt),
  .depth        (depth),
  .work_pending (any_ready),
  .exc_return   (exc_return)
);

// File: tb/tb_nis_sequencer.sv
module tb_nis_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int P          = 2;
  localparam int LIMIT      = 60;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] irq_req;
  logic         cfg_we;
  logic [2:0]   cfg_op;
  logic [1:0]   cfg_idx;
  logic [P-1:0] cfg_data;
  logic         exc_return;
  logic         handler_start;
  logic [1:0]   handler_vec;
  logic         sleep_req;

  int checks = 0;
  int errors = 0;
  int lvl_m[N];

  always #(CLK_PERIOD/2) clk = ~clk;

  nis_sequencer #(.N_IRQ(N), .PRIO_BITS(P)) dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .cfg_we(cfg_we), .cfg_op(cfg_op),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .exc_return(exc_return),
    .handler_start(handler_start), .handler_vec(handler_vec), .sleep_req(sleep_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int op, input int idx, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_op = 3'(op); cfg_idx = 2'(idx); cfg_data = P'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Stimulus is already on the pins; the next edge is edge zero.
  task automatic count_start(output int n, output int vec);
    @(posedge clk); #1;
    irq_req = '0; exc_return = 1'b0; cfg_we = 1'b0;
    n = 0; vec = -1;
    while (n < LIMIT) begin
      @(posedge clk); #1; n++;
      if (handler_start) begin vec = int'(handler_vec); break; end
    end
    @(negedge clk);
  endtask

  task automatic fire(input logic [N-1:0] m, output int n, output int vec);
    irq_req = m;
    count_start(n, vec);
  endtask

  task automatic ret(output int n, output int vec);
    exc_return = 1'b1;
    count_start(n, vec);
  endtask

  function automatic int ref_pick(input bit done[N]);
    int b = -1;
    for (int i = 0; i < N; i++)
      if (!done[i] && (b < 0 || lvl_m[i] < lvl_m[b])) b = i;
    return b;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, v, e;
    rst = 1'b1; irq_req = '0; cfg_we = 1'b0; cfg_op = '0; cfg_idx = '0;
    cfg_data = '0; exc_return = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 reset strobe", int'(handler_start), 0);
    chk("R4 reset vector", int'(handler_vec), 0);
    chk("R9 reset sleep", int'(sleep_req), 0);
    rst = 1'b0;

    for (int i = 0; i < N; i++) cfg(0, i, 0);

    // R3 R7 R8: sweep of level patterns, order against a sort on (level, index)
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 4; s++) begin
        bit done[N];
        for (int i = 0; i < N; i++) begin
          lvl_m[i] = (k * i + s) % 4;
          cfg(2, i, lvl_m[i]);
          done[i] = 1'b0;
        end
        fire('1, n, v);
        e = ref_pick(done); done[e] = 1'b1;
        chk("R4 entry latency", n, 13);
        chk("R3 first vector", v, e);
        for (int j = 1; j < N; j++) begin
          ret(n, v);
          e = ref_pick(done); done[e] = 1'b1;
          chk("R7 chain latency", n, 6);
          chk("R3 chained order", v, e);
        end
        ret(n, v);
        chk("R8 no handler after final restore", v, -1);
      end
    end

    lvl_m[0] = 0; lvl_m[1] = 2; lvl_m[2] = 2; lvl_m[3] = 3;
    for (int i = 0; i < N; i++) cfg(2, i, lvl_m[i]);

    // R2: disabled source stays pending and wins once enabled
    cfg(1, 2, 0);
    fire(4'b0100, n, v);
    chk("R2 disabled source not taken", v, -1);
    cfg_we = 1'b1; cfg_op = 3'd0; cfg_idx = 2'd2; cfg_data = '0;
    count_start(n, v);
    chk("R2 retained pending taken after enable", v, 2);
    chk("R2 entry latency from enable", n, 13);
    ret(n, v);
    chk("R2 pending cleared on entry", v, -1);

    // R1: set-pending write
    cfg_we = 1'b1; cfg_op = 3'd3; cfg_idx = 2'd3; cfg_data = '0;
    count_start(n, v);
    chk("R1 set-pending vector", v, 3);
    chk("R1 set-pending latency", n, 13);
    ret(n, v);
    chk("R1 single handler", v, -1);

    // R5: late arrival three edges into the save phase
    irq_req = 4'b1000;
    @(posedge clk); #1; irq_req = '0; n = 0; v = -1;
    while (n < LIMIT) begin
      @(posedge clk); #1; n++;
      if (n == 3) irq_req = 4'b0001;
      if (n == 4) irq_req = '0;
      if (handler_start) begin v = int'(handler_vec); break; end
    end
    @(negedge clk);
    chk("R5 late arrival vector", v, 0);
    chk("R5 late arrival latency unchanged", n, 13);
    ret(n, v);
    chk("R5 displaced source chains", v, 3);
    chk("R7 chain latency after late arrival", n, 6);
    ret(n, v);
    chk("R8 idle after chain", v, -1);

    // R6: strict preemption and nested unwinding
    fire(4'b0010, n, v);
    chk("R6 outer handler", v, 1);
    fire(4'b0100, n, v);
    chk("R6 equal level does not preempt", v, -1);
    fire(4'b0001, n, v);
    chk("R6 more urgent preempts", v, 0);
    chk("R6 preempt latency", n, 13);
    ret(n, v);
    chk("R6 return resumes level 2, equal waiter held", v, -1);
    ret(n, v);
    chk("R7 waiter chains at thread level", v, 2);
    chk("R7 chain latency after unwind", n, 6);
    ret(n, v);
    chk("R8 idle after unwind", v, -1);

    // R7: return and preempting source in the same cycle
    fire(4'b0010, n, v);
    chk("R7 handler before collision", v, 1);
    irq_req = 4'b0001;
    @(posedge clk); #1; irq_req = '0;
    @(negedge clk); exc_return = 1'b1;
    count_start(n, v);
    chk("R7 collision takes chain path", n, 6);
    chk("R7 collision vector", v, 0);
    ret(n, v);
    chk("R8 idle after collision", v, -1);
    ret(n, v);
    chk("R7 thread-level return ignored", v, -1);
    fire(4'b0010, n, v);
    chk("R7 entry normal after ignored return", n, 13);

    // R8: arrival two edges into the restore phase
    exc_return = 1'b1;
    @(posedge clk); #1; exc_return = 1'b0; n = 0; v = -1;
    while (n < LIMIT) begin
      @(posedge clk); #1; n++;
      if (n == 1) irq_req = 4'b1000;
      if (n == 2) irq_req = '0;
      if (handler_start) begin v = int'(handler_vec); break; end
    end
    @(negedge clk);
    chk("R8 aborted restore vector", v, 3);
    chk("R8 aborted restore latency", n, 9);
    ret(n, v);
    chk("R8 idle after abort", v, -1);

    // R9: sleep on exit
    cfg(4, 0, 1);
    fire(4'b0010, n, v);
    chk("R9 handler before sleep", v, 1);
    exc_return = 1'b1;
    @(posedge clk); #1; exc_return = 1'b0;
    for (int c = 1; c <= 10; c++) begin
      @(posedge clk); #1;
      if (c == 9)  chk("R9 sleep not before restore end", int'(sleep_req), 0);
      if (c == 10) chk("R9 sleep at restore end", int'(sleep_req), 1);
    end
    @(negedge clk);
    cfg(1, 3, 0);
    irq_req = 4'b1000;
    repeat (5) @(negedge clk);
    irq_req = '0;
    chk("R9 disabled arrival keeps sleep", int'(sleep_req), 1);
    irq_req = 4'b0001;
    @(posedge clk); #1; irq_req = '0;
    chk("R9 sleep held at pending edge", int'(sleep_req), 1);
    n = 0; v = -1;
    while (n < LIMIT) begin
      @(posedge clk); #1; n++;
      if (n == 1) chk("R9 sleep falls one edge later", int'(sleep_req), 0);
      if (handler_start) begin v = int'(handler_vec); break; end
    end
    @(negedge clk);
    chk("R9 wake handler vector", v, 0);
    chk("R9 wake handler latency", n, 13);
    ret(n, v);
    chk("R9 sleep again, disabled pending ignored", int'(sleep_req), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule